// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block sets the order in which an LCD panel is powered up and down. It sits between a small register port and three enables: the panel supply-control output, the enable of the display timing generator (frame marker, line clock, shift clock and display-enable outputs), and the enable of the pixel data path. The sequencer does not generate timing or pixel data. It only gates the enables of the logic that does.

A start command raises the supply enable. After a programmed number of frames it raises the timing enable, and after a second programmed number of frames it raises the data enable. A stop command drops the data and timing enables together. After a programmed number of frames it then drops the supply enable. Delays are counted in whole frames from a one-cycle frame-start strobe, and each delay lasts its field value plus one frames. A two-bit status shows the progress of each sequence.

The state machine has six states: `S_OFF` (status 00), `S_UP_SUP` (01), `S_UP_TIM` (10), `S_RUN` (11), `S_DN_STOP` (10) and `S_DN_WAIT` (01). It has six transitions:
- start: `S_OFF`→`S_UP_SUP`
- timing-on: `S_UP_SUP`→`S_UP_TIM`, after the timing delay
- data-on: `S_UP_TIM`→`S_RUN`, after the data delay
- stop: `S_RUN`→`S_DN_STOP`
- settle: `S_DN_STOP`→`S_DN_WAIT`, after one cycle
- supply-off: `S_DN_WAIT`→`S_OFF`, after the off delay

Top module: `lcd_pwr_seq`

## Requirements
- R1: After synchronous reset, the status is 00 and all three enables are low. The delay register reads 0xFFF, so every 4-bit delay field is all ones.
- R2: A write to address 0 with bit 0 = 1 and bit 4 = 1 while the status is 00 starts power-up. On the next cycle the status is 01, the supply enable is high, and the timing and data enables are low.
- R3: In status 01, the timing enable rises and the status becomes 10 on the (T+1)th counted frame strobe. T is delay bits [3:0]. In status 10, the data enable rises and the status becomes 11 on the (D+1)th counted strobe. D is delay bits [7:4].
- R4: A write to address 0 with bit 0 = 0 while the status is 11 starts power-down. On the next cycle the data and timing enables are both low, the supply enable is still high, and the status is 10. On the cycle after that the status is 01.
- R5: In power-down status 01, the supply enable falls and the status becomes 00 on the (F+1)th counted strobe. F is delay bits [11:8].
- R6: A frame strobe is counted only while a delay is running. A strobe in the same cycle as the command write, or in the one-cycle stop state, is not counted.
- R7: Control writes while a sequence is running (status 01 or 10) are ignored and not queued. A write with bit 0 = 1 and bit 4 = 0 in status 00 does not start power-up. A write with bit 0 = 1 in status 11 has no effect.
- R8: Address 0 reads as follows:
  - bit 0 is the display-on flag, set by an accepted start and cleared by an accepted stop.
  - bit 4 always reads 0.
  - bits [9:8] are the status.
  - all other bits read 0.
  
  Address 1 reads the three delay fields at bits [3:0], [7:4] and [11:8], with all other bits 0.
- R9: A high data enable implies a high timing enable, and a high timing enable implies a high supply enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = control, 1 = delays |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register (combinational) |
| frame_stb | input | 1 | One-cycle frame-start strobe |
| supply_en | output | 1 | Panel supply-control enable |
| timing_en | output | 1 | Display timing outputs enable |
| data_en | output | 1 | Pixel data output enable |
| seq_status | output | 2 | Sequence progress code |

## Verification
Two events can fall in the same cycle: a frame strobe and a command write that starts a delay, and likewise a frame strobe and the one-cycle stop state. The bench provokes the first by raising the strobe in the cycle of a start or stop write. It provokes the second by pulsing the strobe in the stop state. In both cases it judges that the transition comes only after a further field-plus-one strobes. A sweep over every combination of delay values 0 to 3 checks the status and enables after each strobe against counts computed in the bench.

// File: rtl/lcd_pwr_pkg.sv
package lcd_pwr_pkg;

    typedef enum logic [2:0] {
        S_OFF     = 3'd0,
        S_UP_SUP  = 3'd1,
        S_UP_TIM  = 3'd2,
        S_RUN     = 3'd3,
        S_DN_STOP = 3'd4,
        S_DN_WAIT = 3'd5
    } seq_state_t;

    localparam logic [1:0] ST_IDLE = 2'b00;
    localparam logic [1:0] ST_LOW  = 2'b01;
    localparam logic [1:0] ST_HIGH = 2'b10;
    localparam logic [1:0] ST_FULL = 2'b11;

endpackage

// File: rtl/lcd_pwr_regs.sv
module lcd_pwr_regs #(
    parameter int DATA_W = 16,
    parameter int DLY_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [1:0]        status,
    input  logic              is_idle,
    input  logic              is_run,
    output logic              cmd_start,
    output logic              cmd_stop,
    output logic [DLY_W-1:0]  tim_dly,
    output logic [DLY_W-1:0]  dat_dly,
    output logic [DLY_W-1:0]  off_dly
);
    localparam int ON_BIT  = 0;
    localparam int GO_BIT  = 4;
    localparam int ST_LSB  = 8;
    localparam int TIM_LSB = 0;
    localparam int DAT_LSB = DLY_W;
    localparam int OFF_LSB = 2 * DLY_W;
    localparam logic [DLY_W-1:0] DLY_RST = '1;

    logic ctl_wr, dly_wr, disp_on_q;

    assign ctl_wr = reg_we && (reg_addr == 1'b0);
    assign dly_wr = reg_we && (reg_addr == 1'b1);

    assign cmd_start = ctl_wr && is_idle && reg_wdata[ON_BIT] && reg_wdata[GO_BIT];
    assign cmd_stop  = ctl_wr && is_run && !reg_wdata[ON_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            disp_on_q <= 1'b0;
            tim_dly   <= DLY_RST;
            dat_dly   <= DLY_RST;
            off_dly   <= DLY_RST;
        end else begin
            if (cmd_start) disp_on_q <= 1'b1;
            else if (cmd_stop) disp_on_q <= 1'b0;
            if (dly_wr) begin
                tim_dly <= reg_wdata[TIM_LSB +: DLY_W];
                dat_dly <= reg_wdata[DAT_LSB +: DLY_W];
                off_dly <= reg_wdata[OFF_LSB +: DLY_W];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == 1'b0) begin
            reg_rdata[ON_BIT]         = disp_on_q;
            reg_rdata[ST_LSB +: 2]    = status;
        end else begin
            reg_rdata[TIM_LSB +: DLY_W] = tim_dly;
            reg_rdata[DAT_LSB +: DLY_W] = dat_dly;
            reg_rdata[OFF_LSB +: DLY_W] = off_dly;
        end
    end

    // R7: commands are never accepted outside idle or running states
    a_r7_cmd_gate: assert property (@(posedge clk) disable iff (rst)
        (cmd_start || cmd_stop) |-> (is_idle || is_run));
    // R8: the self-clearing start bit is never reflected in readback
    a_r8_go_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 1'b0) |-> (reg_rdata[GO_BIT] == 1'b0));

endmodule

// File: rtl/lcd_pwr_frame_cnt.sv
module lcd_pwr_frame_cnt #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             frame_stb,
    input  logic [DLY_W-1:0] target,
    output logic             done
);
    logic [DLY_W-1:0] cnt_q;

    assign done = run && frame_stb && (cnt_q == target);

    always_ff @(posedge clk) begin
        if (rst || !run || done) cnt_q <= '0;
        else if (frame_stb) cnt_q <= cnt_q + 1'b1;
    end

    // R6: strobes outside a running delay leave the count at zero
    a_r6_idle_clear: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0));
    // R6: the count only moves on a strobe
    a_r6_count_on_stb: assert property (@(posedge clk) disable iff (rst)
        (run && !frame_stb) |=> $stable(cnt_q) || !$past(run));

endmodule

// File: rtl/lcd_pwr_fsm.sv
module lcd_pwr_fsm
    import lcd_pwr_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic [DLY_W-1:0] tim_dly,
    input  logic [DLY_W-1:0] dat_dly,
    input  logic [DLY_W-1:0] off_dly,
    input  logic             cnt_done,
    output logic             cnt_run,
    output logic [DLY_W-1:0] cnt_target,
    output logic             supply_en,
    output logic             timing_en,
    output logic             data_en,
    output logic [1:0]       status,
    output logic             is_idle,
    output logic             is_run
);
    seq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF:     if (cmd_start) state_d = S_UP_SUP;
            S_UP_SUP:  if (cnt_done)  state_d = S_UP_TIM;
            S_UP_TIM:  if (cnt_done)  state_d = S_RUN;
            S_RUN:     if (cmd_stop)  state_d = S_DN_STOP;
            S_DN_STOP:                state_d = S_DN_WAIT;
            S_DN_WAIT: if (cnt_done)  state_d = S_OFF;
            default:                  state_d = S_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_OFF;
        else     state_q <= state_d;
    end

    always_comb begin
        supply_en  = 1'b0;
        timing_en  = 1'b0;
        data_en    = 1'b0;
        status     = ST_IDLE;
        cnt_run    = 1'b0;
        cnt_target = off_dly;
        unique case (state_q)
            S_OFF: ;
            S_UP_SUP: begin
                supply_en  = 1'b1;
                status     = ST_LOW;
                cnt_run    = 1'b1;
                cnt_target = tim_dly;
            end
            S_UP_TIM: begin
                supply_en  = 1'b1;
                timing_en  = 1'b1;
                status     = ST_HIGH;
                cnt_run    = 1'b1;
                cnt_target = dat_dly;
            end
            S_RUN: begin
                supply_en = 1'b1;
                timing_en = 1'b1;
                data_en   = 1'b1;
                status    = ST_FULL;
            end
            S_DN_STOP: begin
                supply_en = 1'b1;
                status    = ST_HIGH;
            end
            S_DN_WAIT: begin
                supply_en  = 1'b1;
                status     = ST_LOW;
                cnt_run    = 1'b1;
                cnt_target = off_dly;
            end
            default: ;
        endcase
    end

    assign is_idle = (state_q == S_OFF);
    assign is_run  = (state_q == S_RUN);

    // R9: enables nest
    a_r9_order: assert property (@(posedge clk) disable iff (rst)
        (!data_en || timing_en) && (!timing_en || supply_en));
    // R2: start leads to supply-only state
    a_r2_start: assert property (@(posedge clk) disable iff (rst)
        cmd_start |=> (status == ST_LOW) && supply_en && !timing_en);
    // R4: stop drops data and timing together, supply held
    a_r4_stop: assert property (@(posedge clk) disable iff (rst)
        cmd_stop |=> !data_en && !timing_en && supply_en);
    // R5: supply only falls out of the power-down wait
    a_r5_supply_off: assert property (@(posedge clk) disable iff (rst)
        $fell(supply_en) |-> $past(status) == ST_LOW && !$past(timing_en));
    // R7: a waiting state holds until its count completes
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (cnt_run && !cnt_done) |=> $stable(status));

endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq #(
    parameter int DATA_W = 16,
    parameter int DLY_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              frame_stb,
    output logic              supply_en,
    output logic              timing_en,
    output logic              data_en,
    output logic [1:0]        seq_status
);
    logic             cmd_start, cmd_stop, is_idle, is_run;
    logic             cnt_run, cnt_done;
    logic [DLY_W-1:0] tim_dly, dat_dly, off_dly, cnt_target;

    lcd_pwr_regs #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .status(seq_status), .is_idle(is_idle), .is_run(is_run),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .tim_dly(tim_dly), .dat_dly(dat_dly), .off_dly(off_dly)
    );

    lcd_pwr_fsm #(.DLY_W(DLY_W)) u_fsm (
        .clk(clk), .rst(rst),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .tim_dly(tim_dly), .dat_dly(dat_dly), .off_dly(off_dly),
        .cnt_done(cnt_done), .cnt_run(cnt_run), .cnt_target(cnt_target),
        .supply_en(supply_en), .timing_en(timing_en), .data_en(data_en),
        .status(seq_status), .is_idle(is_idle), .is_run(is_run)
    );

    lcd_pwr_frame_cnt #(.DLY_W(DLY_W)) u_cnt (
        .clk(clk), .rst(rst),
        .run(cnt_run), .frame_stb(frame_stb),
        .target(cnt_target), .done(cnt_done)
    );

    // R1: after reset the panel is fully off
    a_r1_reset_off: assert property (@(posedge clk)
        $past(rst) |-> (seq_status == 2'b00) && !supply_en && !timing_en && !data_en);

endmodule

// File: tb/lcd_pwr_seq_tb.sv
module lcd_pwr_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        frame_stb = 1'b0;
    logic        supply_en, timing_en, data_en;
    logic [1:0]  seq_status;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_pwr_seq u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_stb(frame_stb),
        .supply_en(supply_en), .timing_en(timing_en), .data_en(data_en),
        .seq_status(seq_status)
    );

    // packed view {supply, timing, data, status}
    function automatic logic [4:0] outs();
        return {supply_en, timing_en, data_en, seq_status};
    endfunction

    localparam logic [4:0] O_OFF  = 5'b000_00;
    localparam logic [4:0] O_SUP  = 5'b100_01;
    localparam logic [4:0] O_TIM  = 5'b110_10;
    localparam logic [4:0] O_RUN  = 5'b111_11;
    localparam logic [4:0] O_STOP = 5'b100_10;
    localparam logic [4:0] O_WAIT = 5'b100_01;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycle(input bit we, input bit addr, input logic [15:0] d, input bit stb);
        @(negedge clk);
        reg_we = we; reg_addr = addr; reg_wdata = d; frame_stb = stb;
        @(negedge clk);
        reg_we = 1'b0; frame_stb = 1'b0;
    endtask

    task automatic pulse();
        cycle(1'b0, 1'b0, 16'h0, 1'b1);
    endtask

    task automatic read_reg(input bit addr, output logic [15:0] v);
        reg_addr = addr;
        #1 v = reg_rdata;
    endtask

    task automatic set_delays(input int t, input int d, input int f);
        cycle(1'b1, 1'b1, 16'((f << 8) | (d << 4) | t), 1'b0);
    endtask

    // full up/down run, checking after every strobe
    task automatic run_seq(input int t, input int d, input int f, input bit stb_on_cmd);
        cycle(1'b1, 1'b0, 16'h0011, stb_on_cmd);
        chk("R2 start", outs(), O_SUP);
        for (int k = 1; k <= t + 1; k++) begin
            pulse();
            chk("R3 timing delay", outs(), (k == t + 1) ? O_TIM : O_SUP);
        end
        for (int k = 1; k <= d + 1; k++) begin
            pulse();
            chk("R3 data delay", outs(), (k == d + 1) ? O_RUN : O_TIM);
        end
        cycle(1'b1, 1'b0, 16'h0000, stb_on_cmd);
        chk("R4 stop outputs", outs(), O_STOP);
        @(negedge clk);
        chk("R4 wait state", outs(), O_WAIT);
        for (int k = 1; k <= f + 1; k++) begin
            pulse();
            chk("R5 off delay", outs(), (k == f + 1) ? O_OFF : O_WAIT);
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset outputs", outs(), O_OFF);
        read_reg(1'b1, v);
        chk("R1 default delays", v, 16'h0FFF);
        read_reg(1'b0, v);
        chk("R8 ctl idle read", v, 16'h0000);

        // R7: display-on without start bit does nothing
        cycle(1'b1, 1'b0, 16'h0001, 1'b0);
        chk("R7 no start without bit4", outs(), O_OFF);
        read_reg(1'b0, v);
        chk("R7 flag unchanged", v, 16'h0000);

        // default 16-frame delays
        run_seq(15, 15, 15, 1'b0);

        // R8 readback during run and R7 ignored writes
        set_delays(2, 1, 3);
        read_reg(1'b1, v);
        chk("R8 delay read", v, 16'h0312);
        cycle(1'b1, 1'b0, 16'h0011, 1'b0);
        cycle(1'b1, 1'b0, 16'h0000, 1'b0);
        chk("R7 stop ignored in 01", outs(), O_SUP);
        pulse(); pulse();
        chk("R7 still 01 before 3rd", outs(), O_SUP);
        pulse();
        chk("R3 to 10", outs(), O_TIM);
        cycle(1'b1, 1'b0, 16'h0000, 1'b0);
        chk("R7 stop ignored in 10", outs(), O_TIM);
        pulse(); pulse();
        chk("R3 to 11", outs(), O_RUN);
        read_reg(1'b0, v);
        chk("R8 ctl run read", v, 16'h0301);
        cycle(1'b1, 1'b0, 16'h0011, 1'b0);
        chk("R7 start ignored in 11", outs(), O_RUN);
        // R6: strobe in the stop state is not counted
        cycle(1'b1, 1'b0, 16'h0000, 1'b0);
        chk("R4 stop", outs(), O_STOP);
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        chk("R6 stop state strobe", outs(), O_WAIT);
        for (int k = 1; k <= 4; k++) begin
            pulse();
            chk("R6 off count after stop strobe", outs(), (k == 4) ? O_OFF : O_WAIT);
        end
        read_reg(1'b0, v);
        chk("R8 ctl off read", v, 16'h0000);

        // sweep all small delay combos; odd combos strobe with command (R6)
        for (int t = 0; t < 4; t++)
            for (int d = 0; d < 4; d++)
                for (int f = 0; f < 4; f++) begin
                    set_delays(t, d, f);
                    run_seq(t, d, f, ((t + d + f) % 2) == 1);
                end

        // R1: reset mid-run restores defaults
        set_delays(0, 0, 0);
        cycle(1'b1, 1'b0, 16'h0011, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset mid run", outs(), O_OFF);
        read_reg(1'b1, v);
        chk("R1 delays reloaded", v, 16'h0FFF);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule